// File: doc/BRIEF.md
# Interrupt Presentation Controller with Inter-Processor Request

This block sits between an interrupt source layer and one processor. It keeps one pending interrupt, the processor's current priority and a software request level for inter-processor interrupts. It decides whether a new offer from the source layer is taken or sent back. Priorities are 8-bit values, and a lower value is more favored. 0xFF is the least favored value. It marks "nothing pending" and "masked".

The processor side issues four operations. Accept takes the pending interrupt. End-of-interrupt restores the priority and tells the source layer the handler is done. A priority write changes the current priority. An IPI write sets the request level for an inter-processor interrupt. The IPI competes with source interrupts in the same priority scheme and uses a reserved source number. The controller sends refused or displaced numbers back on reject lanes, forwards end-of-interrupt notices and asks the source layer to resend when it becomes able to take new work.

The pending word has the current priority in bits 31:24 and the source number in bits 23:0. A source number of zero means nothing is pending. Every operation is sampled on a rising clock edge. State and every output pulse change at that edge, so an output pulse lasts one cycle and appears in the cycle after the request.

Top module: `intr_present_unit`

## Requirements
- R1: After reset, `pend_word` is 0 (priority 0, no source), `ipi_level` is 0xFF, `irq_out` is low and no pulse output is active.
- R2: An offer is taken when its priority is strictly below the current priority (`pend_word[31:24]`) and no interrupt is pending at an equal or better priority. After the edge, `pend_word[23:0]` holds the offered number, the pending priority holds the offered priority and `irq_out` is high.
- R3: An offer whose priority is equal to or above the current priority, or not better than a pending interrupt, is refused. In the next cycle `rej_off_valid` pulses with `rej_off_src` equal to the offered number, and the pending state does not change.
- R4: When a taken offer displaces a pending interrupt, `rej_off_valid` pulses with the displaced number in `rej_off_src`.
- R5: Accept shows the whole pending word, as it was before the edge, on `acc_word` with `acc_valid` for one cycle. The current priority becomes the pending priority, the source field becomes 0, the pending priority becomes 0xFF and `irq_out` falls.
- R6: An IPI write stores its value in `ipi_level`. If the value is below the current priority and no interrupt is pending at that value or better, any pending number is rejected on `rej_op_src`. Then the IPI number (parameter, default 2) is latched with the IPI value as pending priority, and `irq_out` is raised.
- R7: A priority write below the old priority evicts a pending interrupt whose priority is not better than the new value. The source field is cleared, the pending priority becomes 0xFF, `irq_out` falls and the old number appears on `rej_op_src`.
- R8: A priority write equal to or above the old priority, with nothing pending, pulses `resend_req`. If `ipi_level` is then below the new priority, the IPI is latched as in R6.
- R9: End-of-interrupt sets the current priority to `eoi_word[31:24]` and pulses `eoi_out_valid` with `eoi_out_src` = `eoi_word[23:0]`. If nothing is pending, it also performs the resend of R8.
- R10: If several processor operations arrive together, only the one highest in the order accept, end-of-interrupt, priority write, IPI write takes effect. An offer in the same cycle is judged against the state that the operation leaves.
- R11: `irq_out` is high exactly when `pend_word[23:0]` is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| offer_valid | input | 1 | Source layer offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_prio | input | 8 | Offered priority |
| accept_req | input | 1 | Processor accepts the pending interrupt |
| eoi_req | input | 1 | Processor signals end of interrupt |
| eoi_word | input | 32 | Priority to restore (31:24) and finished source (23:0) |
| cppr_wr | input | 1 | Processor writes its current priority |
| cppr_data | input | 8 | New current priority |
| ipi_wr | input | 1 | Processor writes the IPI request level |
| ipi_data | input | 8 | New IPI request level |
| irq_out | output | 1 | Level interrupt to the processor |
| pend_word | output | 32 | Current priority (31:24) and pending source (23:0) |
| ipi_level | output | 8 | Stored IPI request level |
| acc_valid | output | 1 | Accept result valid |
| acc_word | output | 32 | Pending word as seen by the accept |
| rej_op_valid | output | 1 | Reject caused by a processor operation |
| rej_op_src | output | 24 | Number rejected by that operation |
| rej_off_valid | output | 1 | Reject caused by offer evaluation |
| rej_off_src | output | 24 | Number rejected by offer evaluation |
| eoi_out_valid | output | 1 | End-of-interrupt notice to the source layer |
| eoi_out_src | output | 24 | Source number finished |
| resend_req | output | 1 | Request to the source layer to resend refused interrupts |

## Verification
A processor operation and a source offer can arrive in the same cycle. Examples are an accept together with a new offer, or an IPI write together with an offer that would displace the same pending interrupt. The bench provokes both the directed cases and a long run in which each operation line and the offer line are raised independently, from a small pool of priorities that produces many ties. Each cycle is judged against a behavioural model that first applies the winning operation and then judges the offer against what remains. Both reject lanes, the pending word and the interrupt line must match that order exactly.

// File: rtl/ipu_pkg.sv
package ipu_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] PRIO_NONE = '1;

  typedef struct packed {
    logic [PRIO_W-1:0] cppr;   // current processor priority
    logic [SRC_W-1:0]  xisr;   // pending source number, 0 = none
    logic [PRIO_W-1:0] pprio;  // priority of the pending source
    logic [PRIO_W-1:0] mfrr;   // inter-processor request level
  } ipu_state_t;

  typedef enum logic [2:0] {
    OP_NONE, OP_ACCEPT, OP_EOI, OP_CPPR, OP_IPI
  } ipu_op_e;

  // An offer is refused when not strictly better than the processor level,
  // or when something at least as favored is already pending.
  function automatic logic offer_loses(input logic [PRIO_W-1:0] cppr,
                                       input logic [SRC_W-1:0]  xisr,
                                       input logic [PRIO_W-1:0] pprio,
                                       input logic [PRIO_W-1:0] prio);
    return (prio >= cppr) || ((xisr != '0) && (pprio <= prio));
  endfunction

  // The IPI leaves the pending entry alone when that entry is at least as good.
  function automatic logic ipi_yields(input logic [SRC_W-1:0]  xisr,
                                      input logic [PRIO_W-1:0] pprio,
                                      input logic [PRIO_W-1:0] mfrr);
    return (xisr != '0) && (pprio <= mfrr);
  endfunction

  function automatic logic cppr_evicts(input logic [PRIO_W-1:0] old_p,
                                       input logic [PRIO_W-1:0] new_p,
                                       input logic [SRC_W-1:0]  xisr,
                                       input logic [PRIO_W-1:0] pprio);
    return (new_p < old_p) && (xisr != '0) && (new_p <= pprio);
  endfunction
endpackage

// File: rtl/ipu_op_stage.sv
module ipu_op_stage
  import ipu_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  ipu_state_t          st_in,
  input  ipu_op_e             op,
  input  logic [WORD_W-1:0]   eoi_word,
  input  logic [PRIO_W-1:0]   cppr_data,
  input  logic [PRIO_W-1:0]   ipi_data,
  output ipu_state_t          st_out,
  output logic                acc_valid,
  output logic [WORD_W-1:0]   acc_word,
  output logic                rej_valid,
  output logic [SRC_W-1:0]    rej_src,
  output logic                eoi_valid,
  output logic [SRC_W-1:0]    eoi_src,
  output logic                resend,
  output logic                evict_ev,
  output logic                ipi_latch_ev
);
  localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

  logic do_ipi;

  always_comb begin
    st_out       = st_in;
    acc_valid    = 1'b0;
    acc_word     = '0;
    rej_valid    = 1'b0;
    rej_src      = '0;
    eoi_valid    = 1'b0;
    eoi_src      = '0;
    resend       = 1'b0;
    evict_ev     = 1'b0;
    ipi_latch_ev = 1'b0;
    do_ipi       = 1'b0;

    case (op)
      OP_ACCEPT: begin
        acc_valid    = 1'b1;
        acc_word     = {st_in.cppr, st_in.xisr};
        st_out.cppr  = st_in.pprio;
        st_out.xisr  = '0;
        st_out.pprio = PRIO_NONE;
      end
      OP_EOI: begin
        st_out.cppr = eoi_word[WORD_W-1:SRC_W];
        eoi_valid   = 1'b1;
        eoi_src     = eoi_word[SRC_W-1:0];
        resend      = (st_in.xisr == '0);
      end
      OP_CPPR: begin
        st_out.cppr = cppr_data;
        if (cppr_evicts(st_in.cppr, cppr_data, st_in.xisr, st_in.pprio)) begin
          evict_ev     = 1'b1;
          rej_valid    = 1'b1;
          rej_src      = st_in.xisr;
          st_out.xisr  = '0;
          st_out.pprio = PRIO_NONE;
        end else if ((cppr_data >= st_in.cppr) && (st_in.xisr == '0)) begin
          resend = 1'b1;
        end
      end
      OP_IPI: begin
        st_out.mfrr = ipi_data;
        do_ipi      = (ipi_data < st_in.cppr);
      end
      default: ;
    endcase

    if (resend && (st_out.mfrr < st_out.cppr)) do_ipi = 1'b1;

    if (do_ipi && !ipi_yields(st_out.xisr, st_out.pprio, st_out.mfrr)) begin
      if (st_out.xisr != '0) begin
        rej_valid = 1'b1;
        rej_src   = st_out.xisr;
      end
      st_out.xisr  = IPI_NUM;
      st_out.pprio = st_out.mfrr;
      ipi_latch_ev = 1'b1;
    end
  end
endmodule

// File: rtl/ipu_offer_stage.sv
module ipu_offer_stage
  import ipu_pkg::*;
(
  input  ipu_state_t        st_in,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  output ipu_state_t        st_out,
  output logic              rej_valid,
  output logic [SRC_W-1:0]  rej_src,
  output logic              take_ev
);
  always_comb begin
    st_out    = st_in;
    rej_valid = 1'b0;
    rej_src   = '0;
    take_ev   = 1'b0;
    if (offer_valid) begin
      if (offer_loses(st_in.cppr, st_in.xisr, st_in.pprio, offer_prio)) begin
        rej_valid = 1'b1;
        rej_src   = offer_src;
      end else begin
        if (st_in.xisr != '0) begin
          rej_valid = 1'b1;
          rej_src   = st_in.xisr;
        end
        st_out.xisr  = offer_src;
        st_out.pprio = offer_prio;
        take_ev      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/intr_present_unit.sv
module intr_present_unit
  import ipu_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              offer_valid,
  input  logic [SRC_W-1:0]  offer_src,
  input  logic [PRIO_W-1:0] offer_prio,
  input  logic              accept_req,
  input  logic              eoi_req,
  input  logic [WORD_W-1:0] eoi_word,
  input  logic              cppr_wr,
  input  logic [PRIO_W-1:0] cppr_data,
  input  logic              ipi_wr,
  input  logic [PRIO_W-1:0] ipi_data,
  output logic              irq_out,
  output logic [WORD_W-1:0] pend_word,
  output logic [PRIO_W-1:0] ipi_level,
  output logic              acc_valid,
  output logic [WORD_W-1:0] acc_word,
  output logic              rej_op_valid,
  output logic [SRC_W-1:0]  rej_op_src,
  output logic              rej_off_valid,
  output logic [SRC_W-1:0]  rej_off_src,
  output logic              eoi_out_valid,
  output logic [SRC_W-1:0]  eoi_out_src,
  output logic              resend_req
);
  ipu_state_t        st_q, st_mid, st_fin;
  ipu_op_e           op;
  logic              op_acc_v, op_rej_v, op_eoi_v, op_resend;
  logic [WORD_W-1:0] op_acc_w;
  logic [SRC_W-1:0]  op_rej_s, op_eoi_s, off_rej_s;
  logic              evict_ev, ipi_latch_ev, take_ev, off_rej_v;
  logic              irq_nxt;
  logic [PRIO_W-1:0] pend_prio;

  // fixed precedence among processor operations
  always_comb begin
    if (accept_req)   op = OP_ACCEPT;
    else if (eoi_req) op = OP_EOI;
    else if (cppr_wr) op = OP_CPPR;
    else if (ipi_wr)  op = OP_IPI;
    else              op = OP_NONE;
  end

  ipu_op_stage #(.IPI_SRC(IPI_SRC)) u_op (
    .st_in(st_q), .op(op), .eoi_word(eoi_word), .cppr_data(cppr_data),
    .ipi_data(ipi_data), .st_out(st_mid), .acc_valid(op_acc_v),
    .acc_word(op_acc_w), .rej_valid(op_rej_v), .rej_src(op_rej_s),
    .eoi_valid(op_eoi_v), .eoi_src(op_eoi_s), .resend(op_resend),
    .evict_ev(evict_ev), .ipi_latch_ev(ipi_latch_ev)
  );

  ipu_offer_stage u_offer (
    .st_in(st_mid), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .st_out(st_fin), .rej_valid(off_rej_v),
    .rej_src(off_rej_s), .take_ev(take_ev)
  );

  // line follows events: dropped by accept or eviction, raised by any latch
  always_comb begin
    irq_nxt = irq_out;
    if (op == OP_ACCEPT || evict_ev) irq_nxt = 1'b0;
    if (ipi_latch_ev || take_ev)     irq_nxt = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q          <= '{cppr: '0, xisr: '0, pprio: PRIO_NONE, mfrr: PRIO_NONE};
      irq_out       <= 1'b0;
      acc_valid     <= 1'b0;
      acc_word      <= '0;
      rej_op_valid  <= 1'b0;
      rej_op_src    <= '0;
      rej_off_valid <= 1'b0;
      rej_off_src   <= '0;
      eoi_out_valid <= 1'b0;
      eoi_out_src   <= '0;
      resend_req    <= 1'b0;
    end else begin
      st_q          <= st_fin;
      irq_out       <= irq_nxt;
      acc_valid     <= op_acc_v;
      acc_word      <= op_acc_w;
      rej_op_valid  <= op_rej_v;
      rej_op_src    <= op_rej_s;
      rej_off_valid <= off_rej_v;
      rej_off_src   <= off_rej_s;
      eoi_out_valid <= op_eoi_v;
      eoi_out_src   <= op_eoi_s;
      resend_req    <= op_resend;
    end
  end

  assign pend_word = {st_q.cppr, st_q.xisr};
  assign pend_prio = st_q.pprio;
  assign ipi_level = st_q.mfrr;
endmodule

// File: rtl/ipu_checker.sv
module ipu_checker
  import ipu_pkg::*;
#(
  parameter int IPI_SRC = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              offer_valid,
  input logic [SRC_W-1:0]  offer_src,
  input logic [PRIO_W-1:0] offer_prio,
  input logic              accept_req,
  input logic              eoi_req,
  input logic [WORD_W-1:0] eoi_word,
  input logic              cppr_wr,
  input logic              ipi_wr,
  input logic [PRIO_W-1:0] ipi_data,
  input logic              irq_out,
  input logic [WORD_W-1:0] pend_word,
  input logic [PRIO_W-1:0] pend_prio,
  input logic              rej_off_valid,
  input logic [SRC_W-1:0]  rej_off_src,
  input logic              eoi_out_valid,
  input logic [SRC_W-1:0]  eoi_out_src
);
  logic no_op;
  assign no_op = !accept_req && !eoi_req && !cppr_wr && !ipi_wr;

  p_irq_tracks_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == (pend_word[SRC_W-1:0] != '0));

  p_accept_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_req && !offer_valid) |=>
      (pend_word[SRC_W-1:0] == '0) && !irq_out &&
      (pend_word[WORD_W-1:SRC_W] == $past(pend_prio)));

  p_refuse_weak_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (offer_valid && no_op && (offer_prio >= pend_word[WORD_W-1:SRC_W])) |=>
      rej_off_valid && (rej_off_src == $past(offer_src)) && $stable(pend_word));

  p_ipi_latch_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ipi_wr && !accept_req && !eoi_req && !cppr_wr && !offer_valid &&
     (ipi_data < pend_word[WORD_W-1:SRC_W]) &&
     ((pend_word[SRC_W-1:0] == '0) || (pend_prio > ipi_data))) |=>
      (pend_word[SRC_W-1:0] == SRC_W'(IPI_SRC)) && (pend_prio == $past(ipi_data)) && irq_out);

  p_eoi_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req && !accept_req) |=>
      eoi_out_valid && (eoi_out_src == $past(eoi_word[SRC_W-1:0])));
endmodule

bind intr_present_unit ipu_checker #(.IPI_SRC(IPI_SRC)) u_ipu_chk (
  .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
  .offer_prio(offer_prio), .accept_req(accept_req), .eoi_req(eoi_req),
  .eoi_word(eoi_word), .cppr_wr(cppr_wr), .ipi_wr(ipi_wr), .ipi_data(ipi_data),
  .irq_out(irq_out), .pend_word(pend_word), .pend_prio(pend_prio),
  .rej_off_valid(rej_off_valid), .rej_off_src(rej_off_src),
  .eoi_out_valid(eoi_out_valid), .eoi_out_src(eoi_out_src)
);

// File: tb/test_intr_present_unit.sv
`timescale 1ns/1ps
module test_intr_present_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic offer_valid = 0, accept_req = 0, eoi_req = 0, cppr_wr = 0, ipi_wr = 0;
  logic [23:0] offer_src = 0;
  logic [7:0]  offer_prio = 0, cppr_data = 0, ipi_data = 0;
  logic [31:0] eoi_word = 0;
  logic        irq_out, acc_valid, rej_op_valid, rej_off_valid, eoi_out_valid, resend_req;
  logic [31:0] pend_word, acc_word;
  logic [7:0]  ipi_level;
  logic [23:0] rej_op_src, rej_off_src, eoi_out_src;

  always #2.5 clk = ~clk;

  intr_present_unit i_intr_present_unit (
    .clk(clk), .rst_n(rst_n), .offer_valid(offer_valid), .offer_src(offer_src),
    .offer_prio(offer_prio), .accept_req(accept_req), .eoi_req(eoi_req),
    .eoi_word(eoi_word), .cppr_wr(cppr_wr), .cppr_data(cppr_data),
    .ipi_wr(ipi_wr), .ipi_data(ipi_data), .irq_out(irq_out),
    .pend_word(pend_word), .ipi_level(ipi_level), .acc_valid(acc_valid),
    .acc_word(acc_word), .rej_op_valid(rej_op_valid), .rej_op_src(rej_op_src),
    .rej_off_valid(rej_off_valid), .rej_off_src(rej_off_src),
    .eoi_out_valid(eoi_out_valid), .eoi_out_src(eoi_out_src),
    .resend_req(resend_req)
  );

  int checks = 0, failures = 0, cycles = 0;
  bit done = 0;

  // behavioural reference model
  int m_lvl, m_src, m_pend, m_ipi, m_irq;
  int e_acc_v, e_acc_w, e_r0_v, e_r0, e_r1_v, e_r1, e_eoi_v, e_eoi, e_res;
  string tag = "R1";
  bit first_after_reset;

  task automatic kick_ipi();
    if (m_src != 0 && m_pend <= m_ipi) return;
    if (m_src != 0) begin e_r0_v = 1; e_r0 = m_src; end
    m_src = 2; m_pend = m_ipi; m_irq = 1;
    tag = "R6";
  endtask

  task automatic do_resend();
    e_res = 1;
    tag = "R8";
    if (m_ipi < m_lvl) kick_ipi();
  endtask

  always @(posedge clk) begin
    int nops;
    e_acc_v = 0; e_acc_w = 0; e_r0_v = 0; e_r0 = 0; e_r1_v = 0; e_r1 = 0;
    e_eoi_v = 0; e_eoi = 0; e_res = 0;
    if (!rst_n) begin
      m_lvl = 0; m_src = 0; m_pend = 255; m_ipi = 255; m_irq = 0;
      tag = "R1"; first_after_reset = 1;
    end else begin
      tag = first_after_reset ? "R1" : "R11";
      first_after_reset = 0;
      nops = int'(accept_req) + int'(eoi_req) + int'(cppr_wr) + int'(ipi_wr);
      if (accept_req) begin
        e_acc_v = 1; e_acc_w = (m_lvl << 24) | m_src;
        m_lvl = m_pend; m_src = 0; m_pend = 255; m_irq = 0; tag = "R5";
      end else if (eoi_req) begin
        m_lvl = int'(eoi_word[31:24]);
        e_eoi_v = 1; e_eoi = int'(eoi_word[23:0]); tag = "R9";
        if (m_src == 0) do_resend();
      end else if (cppr_wr) begin
        int old_l;
        old_l = m_lvl; m_lvl = int'(cppr_data);
        if (m_lvl < old_l) begin
          if (m_src != 0 && m_lvl <= m_pend) begin
            e_r0_v = 1; e_r0 = m_src; m_src = 0; m_pend = 255; m_irq = 0; tag = "R7";
          end
        end else if (m_src == 0) do_resend();
      end else if (ipi_wr) begin
        m_ipi = int'(ipi_data);
        if (m_ipi < m_lvl) kick_ipi();
      end
      if (offer_valid) begin
        int p;
        p = int'(offer_prio);
        if (p >= m_lvl || (m_src != 0 && m_pend <= p)) begin
          e_r1_v = 1; e_r1 = int'(offer_src); tag = "R3";
        end else begin
          if (m_src != 0) begin e_r1_v = 1; e_r1 = m_src; tag = "R4"; end
          else tag = "R2";
          m_src = int'(offer_src); m_pend = p; m_irq = 1;
        end
      end
      if (nops > 1 || (nops > 0 && offer_valid)) tag = "R10";
    end
  end

  // compare every cycle, half a period after the edge
  always @(negedge clk) begin
    logic [149:0] got, exp;
    if (rst_n && !done) begin
      got = {irq_out, pend_word, ipi_level, acc_valid, acc_word, rej_op_valid,
             rej_op_src, rej_off_valid, rej_off_src, eoi_out_valid, eoi_out_src,
             resend_req};
      exp = {m_irq[0], m_lvl[7:0], m_src[23:0], m_ipi[7:0], e_acc_v[0], e_acc_w[31:0],
             e_r0_v[0], e_r0[23:0], e_r1_v[0], e_r1[23:0], e_eoi_v[0], e_eoi[23:0],
             e_res[0]};
      checks++;
      if (got !== exp) begin
        failures++;
        $display("FAIL %s cycle %0d actual=%h expected=%h", tag, cycles, got, exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R11 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic idle();
    offer_valid = 0; accept_req = 0; eoi_req = 0; cppr_wr = 0; ipi_wr = 0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic offer(input int s, input int p);
    offer_valid = 1; offer_src = 24'(s); offer_prio = 8'(p);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    step(); idle();                          // R1 reset state
    cppr_wr = 1; cppr_data = 8'hFF; step(); idle();   // R8 raise with nothing pending
    offer(24'h10, 5); step(); idle();        // R2 take
    offer(24'h11, 7); step(); idle();        // R3 weaker than pending
    offer(24'h12, 3); step(); idle();        // R4 displaces 0x10
    accept_req = 1; step(); idle();          // R5
    offer(24'h13, 3); step(); idle();        // R3 equal to level
    eoi_req = 1; eoi_word = 32'hFF000012; step(); idle();  // R9 with resend
    offer(24'h14, 6); step(); idle();
    ipi_wr = 1; ipi_data = 8'h04; step(); idle();          // R6 replaces 0x14
    cppr_wr = 1; cppr_data = 8'h02; step(); idle();        // R7 evicts IPI
    cppr_wr = 1; cppr_data = 8'h09; step(); idle();        // R8 resend re-raises IPI
    accept_req = 1; offer(24'h15, 1); step(); idle();      // R10 accept plus offer
    cppr_wr = 1; cppr_data = 8'hFF; ipi_wr = 1; ipi_data = 8'h00; step(); idle(); // R10 precedence
    ipi_wr = 1; ipi_data = 8'h03; offer(24'h16, 2); step(); idle();              // R10
    step();
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 8);
      offer_valid = ($urandom_range(0, 1) == 1);
      offer_src   = 24'($urandom_range(3, 63));
      offer_prio  = (r == 8) ? 8'hFF : 8'(r);
      accept_req  = ($urandom_range(0, 5) == 0);
      eoi_req     = ($urandom_range(0, 5) == 0);
      eoi_word    = {(($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 8))),
                     24'($urandom_range(0, 63))};
      cppr_wr     = ($urandom_range(0, 5) == 0);
      cppr_data   = ($urandom_range(0, 3) == 0) ? 8'hFF : 8'($urandom_range(0, 8));
      ipi_wr      = ($urandom_range(0, 6) == 0);
      ipi_data    = ($urandom_range(0, 2) == 0) ? 8'hFF : 8'($urandom_range(0, 8));
      step();
    end
    idle();
    step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule